// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style microcontroller core. Each cycle it takes the working register (W) and a second operand, which is either a file register or an instruction literal. From these it forms an 8-bit result. When the operation is marked valid, it also updates a three-bit status register that holds carry, digit carry and zero. The result and a result-is-zero indication are combinational, so the core's writeback and skip-on-zero logic can use them in the same cycle. The status bits are registered and change on the clock edge that retires the operation.

Each class of operation writes its own set of flags:

- Arithmetic writes all three flags.
- Logic, increment, decrement, complement, clear and move write only zero.
- Rotates pass through carry and write only carry.
- Nibble swap writes nothing.

A mode input, `carryExtend`, makes add and subtract consume the stored carry. This allows multi-byte arithmetic. When the mode is off, add and subtract ignore the stored carry.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 (add) gives result = F + W, plus stored C when `carryExtend` is 1. C takes the carry out of bit 7 and DC the carry out of bit 3.
- R2: Opcode 1 (subtract) gives result = F - W, minus (1 - stored C) when `carryExtend` is 1. C is the inverted borrow out of bit 7, so without extend C = 1 exactly when F >= W. DC is the inverted borrow out of bit 3.
- R3: Opcodes 2/3/4 give F AND W, F OR W and F XOR W. Opcode 5 gives ~F and opcode 6 gives ~W (equal to W XOR 0xFF). Opcode 7 gives F+1 and opcode 8 gives F-1 (mod 256). Opcode 12 gives 0x00 and opcode 13 gives F. All of these write only Z; C and DC hold.
- R4: Opcode 9 rotates left through carry: result = {F[6:0], C} and new C = F[7]. Opcode 10 rotates right through carry: result = {C, F[7:1]} and new C = F[0]. Rotates write only C.
- R5: Opcode 11 swaps nibbles, result = {F[3:0], F[7:4]}, and changes no flag.
- R6: `statusOut` bit 0 is C, bit 1 is DC and bit 2 is Z. After reset all three bits are 0.
- R7: When an operation writes Z, Z becomes 1 exactly when its 8-bit result is 0x00, and 0 otherwise.
- R8: When `opValid` is 0, the status register holds its value whatever the opcode and operands are.
- R9: Opcodes 14 and 15 are reserved. They pass F to the result and change no flag.
- R10: `resultZero` is 1 exactly when `result` is 0x00, for every opcode. This includes operations that do not write Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the status register |
| opValid | input | 1 | Operation retires on this clock edge; enables flag update |
| opCode | input | 4 | Operation select (encoding in R1-R5, R9) |
| wIn | input | 8 | Working register operand |
| fIn | input | 8 | File register or literal operand |
| carryExtend | input | 1 | 1: add and subtract consume the stored carry |
| result | output | 8 | Combinational operation result |
| resultZero | output | 1 | Result equals zero, for skip logic |
| statusOut | output | 3 | Registered flags {Z, DC, C} |

## Verification
The hardest situations to reach are the ones that depend on flag history. A carry-extended subtract must see both a clear and a set incoming carry. A rotate must shift a known carry in. A non-writing operation must leave a flag set by an earlier one untouched. The stimulus table is therefore an ordered program, not a set of independent vectors. Each entry is placed so that the operation before it leaves the exact C, DC and Z state needed: a subtract that borrows, an add that overflows to zero, a rotate right of 0x01. Every entry then checks both the combinational result and the retired flags. Directed steps afterwards cover the idle case, where inputs would change the flags but `opValid` is low, and a reset applied mid-run.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int FLAG_W = 3;
  localparam int C_BIT  = 0;
  localparam int DC_BIT = 1;
  localparam int Z_BIT  = 2;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_NOTF  = 4'd5,
    OP_NOTW  = 4'd6,
    OP_INC   = 4'd7,
    OP_DEC   = 4'd8,
    OP_RL    = 4'd9,
    OP_RR    = 4'd10,
    OP_SWAP  = 4'd11,
    OP_CLR   = 4'd12,
    OP_MOVE  = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } opCode_e;

  typedef enum logic [3:0] {
    SEL_ARITH,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOTF,
    SEL_NOTW,
    SEL_INC,
    SEL_DEC,
    SEL_RL,
    SEL_RR,
    SEL_SWAP,
    SEL_ZERO,
    SEL_PASS
  } resSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSel_e sel;
    logic    invW;      // adder takes ~W (subtract)
    logic    cinUse;    // adder carry-in comes from stored C
    logic    cinFixed;  // adder carry-in when stored C is not used
    logic    wrC;
    logic    wrDC;
    logic    wrZ;
  } aluStrobes_t;

endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic        carryExtend,
  output aluStrobes_t strobes
);

  aluStrobes_t raw;

  always_comb begin
    raw          = '0;
    raw.sel      = SEL_PASS;
    raw.cinUse   = carryExtend;
    unique case (opCode_e'(opCode))
      OP_ADD: begin
        raw.sel      = SEL_ARITH;
        raw.cinFixed = 1'b0;
        raw.wrC      = 1'b1;
        raw.wrDC     = 1'b1;
        raw.wrZ      = 1'b1;
      end
      OP_SUB: begin
        raw.sel      = SEL_ARITH;
        raw.invW     = 1'b1;
        raw.cinFixed = 1'b1;
        raw.wrC      = 1'b1;
        raw.wrDC     = 1'b1;
        raw.wrZ      = 1'b1;
      end
      OP_AND:  begin raw.sel = SEL_AND;  raw.wrZ = 1'b1; end
      OP_OR:   begin raw.sel = SEL_OR;   raw.wrZ = 1'b1; end
      OP_XOR:  begin raw.sel = SEL_XOR;  raw.wrZ = 1'b1; end
      OP_NOTF: begin raw.sel = SEL_NOTF; raw.wrZ = 1'b1; end
      OP_NOTW: begin raw.sel = SEL_NOTW; raw.wrZ = 1'b1; end
      OP_INC:  begin raw.sel = SEL_INC;  raw.wrZ = 1'b1; end
      OP_DEC:  begin raw.sel = SEL_DEC;  raw.wrZ = 1'b1; end
      OP_RL:   begin raw.sel = SEL_RL;   raw.wrC = 1'b1; end
      OP_RR:   begin raw.sel = SEL_RR;   raw.wrC = 1'b1; end
      OP_SWAP: begin raw.sel = SEL_SWAP; end
      OP_CLR:  begin raw.sel = SEL_ZERO; raw.wrZ = 1'b1; end
      OP_MOVE: begin raw.sel = SEL_PASS; raw.wrZ = 1'b1; end
      default: begin raw.sel = SEL_PASS; end
    endcase
  end

  always_comb begin
    strobes      = raw;
    strobes.wrC  = raw.wrC  & opValid;
    strobes.wrDC = raw.wrDC & opValid;
    strobes.wrZ  = raw.wrZ  & opValid;
  end

  // R1 R2: digit carry is written only together with carry and zero
  dc_with_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDC |-> (strobes.wrC && strobes.wrZ));

  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !(strobes.wrC || strobes.wrDC || strobes.wrZ));

endmodule

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] wOp,
  input  logic [DATA_W-1:0] fOp,
  output logic [DATA_W-1:0] resOut,
  output logic              resZero,
  output logic [FLAG_W-1:0] flags
);

  localparam int NIB_W = DATA_W / 2;

  logic              carryQ;
  logic              cin;
  logic [DATA_W-1:0] addB;
  logic [DATA_W:0]   sumFull;
  logic [NIB_W:0]    sumLow;
  logic              carryNext;
  logic [FLAG_W-1:0] flagsNext;

  assign carryQ = flags[C_BIT];
  assign cin    = strobes.cinUse ? carryQ : strobes.cinFixed;
  assign addB   = strobes.invW ? ~wOp : wOp;

  assign sumFull = {1'b0, fOp} + {1'b0, addB} + {{DATA_W{1'b0}}, cin};
  assign sumLow  = {1'b0, fOp[NIB_W-1:0]} + {1'b0, addB[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};

  always_comb begin
    unique case (strobes.sel)
      SEL_ARITH: resOut = sumFull[DATA_W-1:0];
      SEL_AND:   resOut = fOp & wOp;
      SEL_OR:    resOut = fOp | wOp;
      SEL_XOR:   resOut = fOp ^ wOp;
      SEL_NOTF:  resOut = ~fOp;
      SEL_NOTW:  resOut = wOp ^ {DATA_W{1'b1}};
      SEL_INC:   resOut = fOp + {{(DATA_W-1){1'b0}}, 1'b1};
      SEL_DEC:   resOut = fOp - {{(DATA_W-1){1'b0}}, 1'b1};
      SEL_RL:    resOut = {fOp[DATA_W-2:0], carryQ};
      SEL_RR:    resOut = {carryQ, fOp[DATA_W-1:1]};
      SEL_SWAP:  resOut = {fOp[NIB_W-1:0], fOp[DATA_W-1:NIB_W]};
      SEL_ZERO:  resOut = '0;
      default:   resOut = fOp;
    endcase
  end

  assign resZero = (resOut == '0);

  always_comb begin
    unique case (strobes.sel)
      SEL_ARITH: carryNext = sumFull[DATA_W];
      SEL_RL:    carryNext = fOp[DATA_W-1];
      SEL_RR:    carryNext = fOp[0];
      default:   carryNext = carryQ;
    endcase
  end

  always_comb begin
    flagsNext = flags;
    if (strobes.wrC)  flagsNext[C_BIT]  = carryNext;
    if (strobes.wrDC) flagsNext[DC_BIT] = sumLow[NIB_W];
    if (strobes.wrZ)  flagsNext[Z_BIT]  = resZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;
  end

  // R2: plain subtract, carry means no borrow
  sub_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrC && strobes.sel == SEL_ARITH && strobes.invW && !strobes.cinUse)
    |=> flags[C_BIT] == ($past(fOp) >= $past(wOp)));

  // R1: plain add, carry means the sum passed the top
  add_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrC && strobes.sel == SEL_ARITH && !strobes.invW && !strobes.cinUse)
    |=> flags[C_BIT] == ($past(fOp) > ~$past(wOp)));

  // R4: rotate left takes carry from the old top bit, zero untouched
  rl_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrC && strobes.sel == SEL_RL)
    |=> (flags[C_BIT] == $past(fOp[DATA_W-1])) && $stable(flags[Z_BIT]));

  // R5 R8 R9: no write strobe, no flag change
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrC || strobes.wrDC || strobes.wrZ) |=> $stable(flags));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrZ |=> flags[Z_BIT] == ($past(resOut) == '0));

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] wIn,
  input  logic [DATA_W-1:0] fIn,
  input  logic              carryExtend,
  output logic [DATA_W-1:0] result,
  output logic              resultZero,
  output logic [FLAG_W-1:0] statusOut
);

  aluStrobes_t strobes;

  byte_alu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opCode      (opCode),
    .carryExtend (carryExtend),
    .strobes     (strobes)
  );

  byte_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wOp     (wIn),
    .fOp     (fIn),
    .resOut  (result),
    .resZero (resultZero),
    .flags   (statusOut)
  );

endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] wIn = '0;
  logic [7:0] fIn = '0;
  logic       carryExtend = 1'b0;
  logic [7:0] result;
  logic       resultZero;
  logic [2:0] statusOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  byte_alu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .wIn(wIn), .fIn(fIn), .carryExtend(carryExtend),
    .result(result), .resultZero(resultZero), .statusOut(statusOut)
  );

  typedef struct packed {
    logic [3:0] op;
    logic       ext;
    logic [7:0] w;
    logic [7:0] f;
    logic [7:0] res;
    logic [2:0] flg;   // expected {Z, DC, C} after the edge
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 8'h3A, 8'h47, 8'h81, 3'b010},  // R1 nibble carry
    '{4'd0,  1'b0, 8'hC8, 8'h38, 8'h00, 3'b111},  // R1 wrap to zero
    '{4'd0,  1'b1, 8'h10, 8'h20, 8'h31, 3'b000},  // R1 extend, C=1 in
    '{4'd1,  1'b0, 8'h05, 8'h05, 8'h00, 3'b111},  // R2 equal
    '{4'd1,  1'b0, 8'h06, 8'h05, 8'hFF, 3'b000},  // R2 borrow
    '{4'd1,  1'b1, 8'h01, 8'h10, 8'h0E, 3'b001},  // R2 extend, C=0 in
    '{4'd1,  1'b1, 8'h01, 8'h10, 8'h0F, 3'b001},  // R2 extend, C=1 in
    '{4'd9,  1'b0, 8'h00, 8'h41, 8'h83, 3'b000},  // R4 rl with C=1
    '{4'd10, 1'b0, 8'h00, 8'h01, 8'h00, 3'b001},  // R4 rr to zero, Z held
    '{4'd10, 1'b0, 8'h00, 8'h80, 8'hC0, 3'b000},  // R4 rr with C=1
    '{4'd2,  1'b0, 8'hF0, 8'h0F, 8'h00, 3'b100},  // R3 and
    '{4'd3,  1'b0, 8'hF0, 8'h0F, 8'hFF, 3'b000},  // R3 or
    '{4'd4,  1'b0, 8'hAA, 8'hAA, 8'h00, 3'b100},  // R3 xor
    '{4'd0,  1'b0, 8'h80, 8'h80, 8'h00, 3'b101},  // R1 set C, clear DC
    '{4'd5,  1'b0, 8'h00, 8'h0F, 8'hF0, 3'b001},  // R3 not F, C held
    '{4'd6,  1'b0, 8'h5A, 8'h00, 8'hA5, 3'b001},  // R3 not W
    '{4'd7,  1'b0, 8'h00, 8'hFF, 8'h00, 3'b101},  // R3 inc wrap, C held
    '{4'd8,  1'b0, 8'h00, 8'h00, 8'hFF, 3'b001},  // R3 dec wrap
    '{4'd11, 1'b0, 8'h00, 8'h3C, 8'hC3, 3'b001},  // R5 swap
    '{4'd12, 1'b0, 8'h12, 8'h34, 8'h00, 3'b101},  // R3 clear
    '{4'd13, 1'b0, 8'h00, 8'h00, 8'h00, 3'b101},  // R3 move zero
    '{4'd13, 1'b0, 8'h00, 8'h7E, 8'h7E, 3'b001},  // R3 move
    '{4'd14, 1'b0, 8'hFF, 8'h55, 8'h55, 3'b001},  // R9 reserved
    '{4'd15, 1'b0, 8'h00, 8'h00, 8'h00, 3'b001},  // R9 reserved zero
    '{4'd11, 1'b0, 8'h00, 8'h00, 8'h00, 3'b001},  // R5 swap zero
    '{4'd0,  1'b1, 8'hFF, 8'h00, 8'h00, 3'b111},  // R1 extend wrap
    '{4'd0,  1'b1, 8'h0F, 8'h00, 8'h10, 3'b010}   // R1 extend DC only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0:         return "R1";
      4'd1:         return "R2";
      4'd9, 4'd10:  return "R4";
      4'd11:        return "R5";
      4'd14, 4'd15: return "R9";
      default:      return "R3";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 reset flags", {29'd0, statusOut}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opValid     = 1'b1;
      opCode      = VECS[i].op;
      wIn         = VECS[i].w;
      fIn         = VECS[i].f;
      carryExtend = VECS[i].ext;
      #2;
      check({reqOf(VECS[i].op), " result"}, {24'd0, result}, {24'd0, VECS[i].res});
      // R10
      check("R10 resultZero", {31'd0, resultZero}, {31'd0, (VECS[i].res == 8'h00)});
      @(negedge clk);
      opValid = 1'b0;
      // R6 R7: flag layout {Z,DC,C}
      check({reqOf(VECS[i].op), " R7 flags"}, {29'd0, statusOut}, {29'd0, VECS[i].flg});
    end

    // R8: idle, inputs that would overflow to zero
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd1; wIn = 8'hFF; fIn = 8'h00; carryExtend = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 idle flags held", {29'd0, statusOut}, {29'd0, 3'b010});

    // R6: reset mid-run clears flags
    opValid = 1'b1; opCode = 4'd0; wIn = 8'h01; fIn = 8'hFF;
    @(negedge clk);
    check("R1 pre-reset flags", {29'd0, statusOut}, {29'd0, 3'b111});
    rstN = 1'b0;
    #2;
    check("R6 reset mid-run", {29'd0, statusOut}, 32'd0);
    opValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule